// File: doc/BRIEF.md
# Receive Holding FIFO with Status Flags

This block sits on one serial channel between the receive shift register and the host. Each received character is stored together with its parity-error, framing-error and break bits in a receive queue of `DEPTH` entries (sixteen by default). The block produces four status flags: receiver-ready, queue-full, a sticky overrun flag, and a receive interrupt flag whose fill threshold is chosen by a 2-bit select.

When the queue is full, the next completed character is not lost at once. It waits in a single holding slot that stands in for the shift register. The next host read frees a position, and the waiting character moves into that position in the same cycle. Because of this, occupancy stays at the maximum across that read, and the full flag only drops on the second read. If another character completes while one is already waiting, the waiting character and its status are discarded, the newest character takes the slot, and overrun is latched until the host issues the clear command.

All flags and the read data are registered. Each of them reflects the stimulus of the previous clock edge.

Top module: `rx_hold_fifo_status`

## Requirements
- R1: While `rst` is high, and on the first edge after it is released, `rx_ready`, `fifo_full`, `overrun`, `lvl_irq` and all four read-data outputs are 0.
- R2: Characters come out in arrival order, each with its own perr/ferr/brk bits. A read strobe accepted at edge N shows the oldest entry on the read outputs from edge N onward, and those outputs hold until the next accepted read.
- R3: `rx_ready` becomes 1 after the edge that pushes a character into an empty queue. It becomes 0 after the edge of the read that leaves the queue empty. Whenever `fifo_full` is 1, `rx_ready` is also 1.
- R4: `fifo_full` becomes 1 after the push that makes the occupancy `DEPTH`. It clears after a read that leaves one position free, and occupancy never exceeds `DEPTH`.
- R5: A character that completes while the queue is full waits in the holding slot with no loss and no overrun. The first following read moves it into the queue in the same cycle, so `fifo_full` stays 1 and only clears after the second read. The waiting character is read out after all characters that arrived before it.
- R6: A character that completes while the queue is full and the holding slot is occupied sets `overrun`. The waiting character is discarded and the new one takes the slot.
- R7: `overrun` stays 1 until a `clr_err` pulse, and clears after that edge. If an overrun occurs at the same edge as `clr_err`, `overrun` stays set.
- R8: With `lvl_sel` = 00, `lvl_irq` is 1 exactly when at least one character is stored.
- R9: With `lvl_sel` = 01, `lvl_irq` is 1 when the occupancy is at least `DEPTH`/2 (8). With `lvl_sel` = 10, it is 1 when the occupancy is at least 3·`DEPTH`/4 (12).
- R10: With `lvl_sel` = 11, `lvl_irq` follows `fifo_full`: it is low whenever the queue is not full. A read that pulls a waiting character in keeps it high.
- R11: A read strobe on an empty queue changes neither the read outputs nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a character has completed |
| rx_data | input | DATA_W | Received character |
| rx_perr | input | 1 | Parity error of the received character |
| rx_ferr | input | 1 | Framing error of the received character |
| rx_brk | input | 1 | Break indication of the received character |
| rd_en | input | 1 | Host read strobe for the queue |
| clr_err | input | 1 | Clear-error-status command (clears overrun) |
| lvl_sel | input | 2 | Interrupt threshold: 00 any, 01 half, 10 three-quarter, 11 full |
| rd_data | output | DATA_W | Character from the last accepted read |
| rd_perr | output | 1 | Parity error of that character |
| rd_ferr | output | 1 | Framing error of that character |
| rd_brk | output | 1 | Break bit of that character |
| rx_ready | output | 1 | At least one character stored |
| fifo_full | output | 1 | All DEPTH positions occupied |
| overrun | output | 1 | Sticky character-loss flag |
| lvl_irq | output | 1 | Receive interrupt flag at the selected threshold |

## Verification
The bench builds the block with the default `DEPTH` = 16 and `DATA_W` = 8. These values give exact threshold boundaries at 8, 12 and 16 entries, and the full-plus-waiting condition can be reached in a short run. The table walk puts each threshold one entry below and at its boundary. The directed tests cover the waiting-slot hand-off on the first read, the second-read clear of `fifo_full`, overrun with replacement of the waiting character, clear colliding with a set, and reads on an empty queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Per-character receive status kept next to each stored character.
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rxq_stat_t;

  localparam int STAT_W = 3;

  // Interrupt threshold select codes.
  typedef enum logic [1:0] {
    LVL_ANY  = 2'b00,
    LVL_HALF = 2'b01,
    LVL_3Q   = 2'b10,
    LVL_FULL = 2'b11
  } rxq_lvl_e;

endpackage

// File: rtl/rxq_store.sv
// Simple dual-port storage with a registered read port, so that block RAM can be inferred.
module rxq_store #(
  parameter int W     = 11,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_q
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Read-before-write: a read and a write at the same address return the old entry.
  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/rxq_ctrl.sv
// Occupancy, pointers, holding slot and overrun.
module rxq_ctrl #(
  parameter int W     = 11,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [W-1:0]  rx_entry,
  input  logic          rd_en,
  input  logic          clr_err,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [W-1:0]  wr_data,
  output logic          rd_go,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] occ_nx,
  output logic [CW-1:0] occ,
  output logic          hold_vld,
  output logic          overrun
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [W-1:0]  hold_q, hold_n;
  logic          hv_n;
  logic          push, pop, room, ovr_set;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  assign pop  = rd_en && (occ != '0);
  assign room = (occ < FULL_CNT) || pop;

  always_comb begin
    push    = 1'b0;
    wr_data = rx_entry;
    hold_n  = hold_q;
    hv_n    = hold_vld;
    ovr_set = 1'b0;
    if (hold_vld) begin
      if (pop) begin
        // The waiting character fills the position this read frees.
        push    = 1'b1;
        wr_data = hold_q;
        if (rx_valid) hold_n = rx_entry;
        else          hv_n   = 1'b0;
      end else if (rx_valid) begin
        // Slot already taken: the older waiting character is lost.
        ovr_set = 1'b1;
        hold_n  = rx_entry;
      end
    end else if (rx_valid) begin
      if (room) begin
        push = 1'b1;
      end else begin
        hv_n   = 1'b1;
        hold_n = rx_entry;
      end
    end
  end

  assign occ_nx  = occ + CW'(push) - CW'(pop);
  assign wr_en   = push;
  assign wr_addr = wptr_q;
  assign rd_go   = pop;
  assign rd_addr = rptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      occ      <= '0;
      hold_vld <= 1'b0;
      hold_q   <= '0;
      overrun  <= 1'b0;
    end else begin
      if (push) wptr_q <= bump(wptr_q);
      if (pop)  rptr_q <= bump(rptr_q);
      occ      <= occ_nx;
      hold_vld <= hv_n;
      hold_q   <= hold_n;
      if (ovr_set)      overrun <= 1'b1;
      else if (clr_err) overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/rxq_level.sv
// Registered flags derived from the next occupancy.
module rxq_level
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] occ_nx,
  input  logic [1:0]    lvl_sel,
  output logic          rx_ready,
  output logic          fifo_full,
  output logic          lvl_irq
);

  localparam logic [CW-1:0] TH_HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] TH_3Q   = CW'((DEPTH * 3) / 4);
  localparam logic [CW-1:0] TH_FULL = CW'(DEPTH);

  logic lvl_nx;
  rxq_lvl_e sel;

  assign sel = rxq_lvl_e'(lvl_sel);

  always_comb begin
    unique case (sel)
      LVL_ANY:  lvl_nx = (occ_nx != '0);
      LVL_HALF: lvl_nx = (occ_nx >= TH_HALF);
      LVL_3Q:   lvl_nx = (occ_nx >= TH_3Q);
      default:  lvl_nx = (occ_nx == TH_FULL);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ready  <= 1'b0;
      fifo_full <= 1'b0;
      lvl_irq   <= 1'b0;
    end else begin
      rx_ready  <= (occ_nx != '0);
      fifo_full <= (occ_nx == TH_FULL);
      lvl_irq   <= lvl_nx;
    end
  end

endmodule

// File: rtl/rx_hold_fifo_status.sv
module rx_hold_fifo_status
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  input  logic              rd_en,
  input  logic              clr_err,
  input  logic [1:0]        lvl_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              rd_brk,
  output logic              rx_ready,
  output logic              fifo_full,
  output logic              overrun,
  output logic              lvl_irq
);

  localparam int W  = DATA_W + STAT_W;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rxq_stat_t     in_stat, out_stat;
  logic [W-1:0]  rx_entry, wr_data, rd_q;
  logic [AW-1:0] wr_addr, rd_addr;
  logic          wr_en, rd_go, hold_vld;
  logic [CW-1:0] occ_nx, occ;

  assign in_stat  = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr};
  assign rx_entry = {in_stat, rx_data};

  rxq_ctrl #(.W(W), .DEPTH(DEPTH)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_entry (rx_entry),
    .rd_en    (rd_en),
    .clr_err  (clr_err),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_go    (rd_go),
    .rd_addr  (rd_addr),
    .occ_nx   (occ_nx),
    .occ      (occ),
    .hold_vld (hold_vld),
    .overrun  (overrun)
  );

  rxq_store #(.W(W), .DEPTH(DEPTH)) store_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_go),
    .rd_addr (rd_addr),
    .rd_q    (rd_q)
  );

  rxq_level #(.DEPTH(DEPTH)) level_i (
    .clk       (clk),
    .rst       (rst),
    .occ_nx    (occ_nx),
    .lvl_sel   (lvl_sel),
    .rx_ready  (rx_ready),
    .fifo_full (fifo_full),
    .lvl_irq   (lvl_irq)
  );

  assign out_stat = rxq_stat_t'(rd_q[W-1:DATA_W]);
  assign rd_data  = rd_q[DATA_W-1:0];
  assign rd_perr  = out_stat.perr;
  assign rd_ferr  = out_stat.ferr;
  assign rd_brk   = out_stat.brk;

endmodule

// File: rtl/rx_hold_fifo_status_chk.sv
module rx_hold_fifo_status_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rd_en,
  input logic              clr_err,
  input logic [1:0]        lvl_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              rx_ready,
  input logic              fifo_full,
  input logic              overrun,
  input logic              lvl_irq,
  input logic              hold_vld,
  input logic [CW-1:0]     occ
);

  p_occ_bound_r4: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  p_hold_needs_full_r5: assert property (@(posedge clk) disable iff (rst)
    hold_vld |-> fifo_full);

  p_full_has_data_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> rx_ready);

  p_ovr_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_valid));

  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overrun && !clr_err |=> overrun);

  p_ovr_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr_err && !rx_valid |=> !overrun);

  p_empty_read_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en && !rx_ready |=> $stable(rd_data));

  p_any_mode_r8: assert property (@(posedge clk) disable iff (rst)
    (lvl_sel == 2'b00) |=> (lvl_irq == rx_ready));

  p_full_mode_r10: assert property (@(posedge clk) disable iff (rst)
    (lvl_sel == 2'b11) |=> (lvl_irq == fifo_full));

endmodule

bind rx_hold_fifo_status rx_hold_fifo_status_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rx_valid  (rx_valid),
  .rd_en     (rd_en),
  .clr_err   (clr_err),
  .lvl_sel   (lvl_sel),
  .rd_data   (rd_data),
  .rx_ready  (rx_ready),
  .fifo_full (fifo_full),
  .overrun   (overrun),
  .lvl_irq   (lvl_irq),
  .hold_vld  (hold_vld),
  .occ       (occ)
);

// File: tb/rx_hold_fifo_status_tb_top.sv
module rx_hold_fifo_status_tb_top;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rx_valid = 1'b0;
  logic [DATA_W-1:0] rx_data = '0;
  logic              rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic              rd_en = 1'b0, clr_err = 1'b0;
  logic [1:0]        lvl_sel = 2'b00;
  logic [DATA_W-1:0] rd_data;
  logic              rd_perr, rd_ferr, rd_brk;
  logic              rx_ready, fifo_full, overrun, lvl_irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rx_hold_fifo_status #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .rd_en(rd_en), .clr_err(clr_err), .lvl_sel(lvl_sel),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .rx_ready(rx_ready), .fifo_full(fifo_full), .overrun(overrun), .lvl_irq(lvl_irq)
  );

  // Threshold table: {fill count[4:0], lvl_sel[1:0], expected lvl_irq}
  localparam int NROW = 10;
  localparam logic [7:0] LVL_TAB [NROW] = '{
    {5'd0,  2'b00, 1'b0}, {5'd1,  2'b00, 1'b1},
    {5'd7,  2'b01, 1'b0}, {5'd8,  2'b01, 1'b1},
    {5'd11, 2'b10, 1'b0}, {5'd12, 2'b10, 1'b1},
    {5'd15, 2'b11, 1'b0}, {5'd16, 2'b11, 1'b1},
    {5'd16, 2'b00, 1'b1}, {5'd8,  2'b10, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_valid = 1'b0; rd_en = 1'b0; clr_err = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
    rx_valid = 1'b1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pull();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) push(8'h40 + 8'(i), i[0], i[1], i[2]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    check("R1 flags in reset", {28'd0, rx_ready, fifo_full, overrun, lvl_irq}, 32'd0);
    do_reset();
    check("R1 flags after reset", {28'd0, rx_ready, fifo_full, overrun, lvl_irq}, 32'd0);
    check("R1 read data after reset", {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, 32'd0);

    // Table walk over the thresholds (R8, R9, R10, R3, R4)
    for (int r = 0; r < NROW; r++) begin
      do_reset();
      fill(int'(LVL_TAB[r][7:3]));
      lvl_sel = LVL_TAB[r][2:1];
      @(negedge clk);
      check("R8/R9/R10 lvl_irq at threshold", {31'd0, lvl_irq}, {31'd0, LVL_TAB[r][0]});
      check("R3 rx_ready vs fill", {31'd0, rx_ready}, {31'd0, LVL_TAB[r][7:3] != 5'd0});
      check("R4 fifo_full vs fill", {31'd0, fifo_full}, {31'd0, LVL_TAB[r][7:3] == 5'd16});
    end
    lvl_sel = 2'b00;

    // R2, R3: order and per-character status
    do_reset();
    push(8'h11, 1'b1, 1'b0, 1'b0);
    check("R3 ready after first push", {31'd0, rx_ready}, 32'd1);
    push(8'h22, 1'b0, 1'b1, 1'b0);
    push(8'h33, 1'b0, 1'b0, 1'b1);
    pull();
    check("R2 first read", {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, 3'b001, 8'h11});
    pull();
    check("R2 second read", {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, 3'b010, 8'h22});
    check("R3 ready with one left", {31'd0, rx_ready}, 32'd1);
    pull();
    check("R2 third read", {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, 3'b100, 8'h33});
    check("R3 ready cleared when empty", {31'd0, rx_ready}, 32'd0);

    // R11: read on empty queue
    pull();
    check("R11 empty read keeps data", {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, 3'b100, 8'h33});
    check("R11 empty read keeps flags", {28'd0, rx_ready, fifo_full, overrun, lvl_irq}, 32'd0);

    // R4, R5, R10: waiting character hand-off
    do_reset();
    lvl_sel = 2'b11;
    fill(DEPTH);
    check("R4 full after last push", {31'd0, fifo_full}, 32'd1);
    push(8'hA5, 1'b1, 1'b1, 1'b0);
    check("R5 no overrun on first wait", {31'd0, overrun}, 32'd0);
    check("R5 still full while waiting", {31'd0, fifo_full}, 32'd1);
    pull();
    check("R5 oldest read first", {24'd0, rd_data}, 32'h40);
    check("R5 full held after first read", {31'd0, fifo_full}, 32'd1);
    check("R10 lvl_irq held by hand-off", {31'd0, lvl_irq}, 32'd1);
    pull();
    check("R4 full cleared after second read", {31'd0, fifo_full}, 32'd0);
    check("R10 lvl_irq low when not full", {31'd0, lvl_irq}, 32'd0);
    for (int i = 2; i < DEPTH; i++) pull();
    pull();
    check("R5 waiting char read last", {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, 3'b011, 8'hA5});
    check("R3 empty after drain", {31'd0, rx_ready}, 32'd0);
    lvl_sel = 2'b00;

    // R6, R7: overrun, replacement and clear
    do_reset();
    fill(DEPTH);
    push(8'h5A, 1'b0, 1'b0, 1'b0);
    push(8'h6B, 1'b0, 1'b0, 1'b1);
    check("R6 overrun set", {31'd0, overrun}, 32'd1);
    repeat (3) @(negedge clk);
    check("R7 overrun sticky", {31'd0, overrun}, 32'd1);
    clr_err = 1'b1;
    @(negedge clk);
    clr_err = 1'b0;
    check("R7 overrun cleared", {31'd0, overrun}, 32'd0);
    for (int i = 0; i < DEPTH; i++) pull();
    pull();
    check("R6 newest replaced waiting", {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, 3'b100, 8'h6B});

    // R7: set wins over a simultaneous clear
    do_reset();
    fill(DEPTH);
    push(8'h33, 1'b0, 1'b0, 1'b0);
    clr_err = 1'b1;
    push(8'h44, 1'b0, 1'b0, 1'b0);
    clr_err = 1'b0;
    check("R7 set beats clear", {31'd0, overrun}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule